// File: doc/BRIEF.md
# Directed Rounding and Overflow Unit

This block is the rounding stage of a floating-point datapath. It takes a sign, a mantissa whose two lowest bits are the guard bit (bit 1) and the round bit (bit 0), a separate sticky bit, and a 2-bit rounding-mode field. It removes the guard and round bits from the mantissa. Under the selected direction it may add one to what remains. It also reports whether the value was inexact and whether it was rounded up.

The round-up output lets the caller spot a carry into the next binade. When the mantissa's leading one was at the top position below the headroom bit, a carry leaves the mantissa in the "2.0" form. The block passes that value on unchanged, and the caller renormalises it.

A second output serves the caller's overflow path. It tells the caller whether an overflowing result with the given sign should become infinity or the largest finite magnitude.

The block is purely combinational. Exponent arithmetic, packing and exception delivery are done elsewhere.

Top module: `dir_round_unit`

## Requirements
- R1: The guard and round bits (mant_i[1:0]) never reach the output. When no increment happens, mant_o equals mant_i[MANT_W-1:2].
- R2: When guard, round and sticky are all zero, the value is exact: mant_o is the shifted mantissa, round_up_o is 0 and inexact_o is 0, whatever the mode and sign.
- R3: inexact_o is 1 whenever any of guard, round or sticky is 1, in every rounding mode.
- R4: In mode 2'b00 (nearest, ties to even), the block increments only when guard is 1 and at least one of these is 1: round, sticky, or the shifted mantissa's LSB (mant_i[2]).
- R5: In mode 2'b01 (toward zero), the block never increments.
- R6: In mode 2'b10 (toward plus infinity), the block increments exactly when the value is inexact and sign_i is 0.
- R7: In mode 2'b11 (toward minus infinity), the block increments exactly when the value is inexact and sign_i is 1.
- R8: The increment adds one with full carry propagation across every output bit. A shifted mantissa of 0x7FFFFF (default width) that rounds up gives 0x800000, the 2.0 form, unchanged.
- R9: round_up_o is 1 exactly when mant_o equals the shifted mantissa plus one.
- R10: ovf_to_inf_o is 1 in mode 2'b00 for both signs and 0 in mode 2'b01 for both signs. In mode 2'b10 it equals !sign_i, and in mode 2'b11 it equals sign_i. It does not depend on the mantissa or on sticky.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sign_i | input | 1 | Sign of the value, 1 = negative |
| mant_i | input | MANT_W | Mantissa, with guard in bit 1 and round in bit 0 |
| sticky_i | input | 1 | OR of all bits below the round bit |
| mode_i | input | 2 | Rounding direction: 00 nearest, 01 toward zero, 10 toward +inf, 11 toward -inf |
| mant_o | output | MANT_W-2 | Rounded mantissa with guard and round removed |
| round_up_o | output | 1 | 1 when an increment was applied |
| inexact_o | output | 1 | 1 when any discarded bit was nonzero |
| ovf_to_inf_o | output | 1 | 1 when an overflow of this sign goes to infinity, 0 when it goes to the largest finite value |

## Verification
The bench targets the nearest-mode tie. Here guard is set with round and sticky clear, and only the LSB decides; a design that rounded half-up would bump even values. The bench sets sticky alone with guard and round clear. A design that ignored sticky would miss inexact and would not increment in the directed modes. Long carry chains across chunk borders, including the all-ones-to-2.0 case, expose an incrementer that drops a carry. The bench sweeps every mode and sign pair for the overflow choice, which catches swapped plus and minus infinity modes.

// File: rtl/dir_round_pkg.sv
// Shared types for the directed rounding unit.
package dir_round_pkg;

    // Rounding direction; encoding is fixed at the block's port.
    typedef enum logic [1:0] {
        RMODE_NEAREST = 2'b00,
        RMODE_TOZERO  = 2'b01,
        RMODE_POSINF  = 2'b10,
        RMODE_NEGINF  = 2'b11
    } rmode_e;

endpackage

// File: rtl/round_decide.sv
// Decides whether the truncated mantissa must be incremented and whether
// the value is inexact. Assumes the guard, round, sticky and LSB inputs
// are already separated by the caller. Combinational.
module round_decide
    import dir_round_pkg::*;
(
    input  logic   sign_i,
    input  logic   guard_i,
    input  logic   rbit_i,
    input  logic   sticky_i,
    input  logic   lsb_i,
    input  rmode_e mode_i,
    output logic   inc_o,
    output logic   inexact_o
);

    logic lost;

    // Any discarded bit makes the value inexact.
    always_comb begin
        lost      = guard_i | rbit_i | sticky_i;
        inexact_o = lost;
    end

    // Direction-dependent increment decision.
    always_comb begin
        unique case (mode_i)
            RMODE_TOZERO: inc_o = 1'b0;
            RMODE_POSINF: inc_o = lost & ~sign_i;
            RMODE_NEGINF: inc_o = lost & sign_i;
            default:      inc_o = guard_i & (rbit_i | sticky_i | lsb_i);
        endcase
    end

endmodule

// File: rtl/chunk_incr.sv
// Adds a single carry-in to a W-bit value. Carry propagates between
// chunks of CHUNK_W bits, so a long run of ones is handled in full.
// Assumes CHUNK_W >= 1. Carry out of the top bit is discarded (the
// caller keeps headroom). Combinational.
module chunk_incr #(
    parameter int W       = 24,
    parameter int CHUNK_W = 8
) (
    input  logic [W-1:0] val_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o
);

    localparam int NCHUNK = (W + CHUNK_W - 1) / CHUNK_W;

    logic [NCHUNK-1:0] carry;

    // The lowest chunk takes the external carry-in.
    assign carry[0] = cin_i;

    for (genvar i = 0; i < NCHUNK; i++) begin : g_chunk
        localparam int LO = i * CHUNK_W;
        localparam int HI = ((LO + CHUNK_W) > W) ? (W - 1) : (LO + CHUNK_W - 1);
        localparam int CW = HI - LO + 1;

        // Chunk sum with the carry arriving from below.
        assign sum_o[HI:LO] = val_i[HI:LO] + CW'(carry[i]);

        if (i < NCHUNK - 1) begin : g_next
            // A carry leaves this chunk only when it is all ones.
            assign carry[i+1] = carry[i] & (&val_i[HI:LO]);
        end
    end

endmodule

// File: rtl/ovf_select.sv
// Chooses, per rounding direction and sign, whether an overflowing
// result becomes infinity (1) or the largest finite magnitude (0).
// Combinational.
module ovf_select
    import dir_round_pkg::*;
(
    input  logic   sign_i,
    input  rmode_e mode_i,
    output logic   to_inf_o
);

    // Direction table for the overflow saturation choice.
    always_comb begin
        unique case (mode_i)
            RMODE_TOZERO: to_inf_o = 1'b0;
            RMODE_POSINF: to_inf_o = ~sign_i;
            RMODE_NEGINF: to_inf_o = sign_i;
            default:      to_inf_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/dir_round_unit.sv
// Directed rounding stage. Strips guard (bit 1) and round (bit 0) from
// the mantissa, increments the rest per rounding direction, and flags
// inexact, round-up and the overflow saturation choice. Assumes the
// caller leaves headroom above the leading one for a carry to 2.0.
// Combinational.
module dir_round_unit
    import dir_round_pkg::*;
#(
    parameter int MANT_W  = 26,
    parameter int CHUNK_W = 8
) (
    input  logic              sign_i,
    input  logic [MANT_W-1:0] mant_i,
    input  logic              sticky_i,
    input  logic [1:0]        mode_i,
    output logic [MANT_W-3:0] mant_o,
    output logic              round_up_o,
    output logic              inexact_o,
    output logic              ovf_to_inf_o
);

    localparam int OUT_W = MANT_W - 2;

    rmode_e           mode;
    logic [OUT_W-1:0] trunc;
    logic             inc;

    // Split the mantissa into kept bits and the guard/round pair.
    always_comb begin
        mode  = rmode_e'(mode_i);
        trunc = mant_i[MANT_W-1:2];
    end

    round_decide u_decide (
        .sign_i    (sign_i),
        .guard_i   (mant_i[1]),
        .rbit_i    (mant_i[0]),
        .sticky_i  (sticky_i),
        .lsb_i     (mant_i[2]),
        .mode_i    (mode),
        .inc_o     (inc),
        .inexact_o (inexact_o)
    );

    chunk_incr #(.W(OUT_W), .CHUNK_W(CHUNK_W)) u_incr (
        .val_i (trunc),
        .cin_i (inc),
        .sum_o (mant_o)
    );

    ovf_select u_ovf (
        .sign_i   (sign_i),
        .mode_i   (mode),
        .to_inf_o (ovf_to_inf_o)
    );

    // Round-up report follows the increment decision.
    assign round_up_o = inc;

    // Cross-checks between the decision, incrementer and selector outputs.
    always_comb begin
        // R1
        no_inc_pass_chk: assert (inc || (mant_o == trunc));
        // R9
        inc_plus_one_chk: assert (!inc || (mant_o == trunc + {{(OUT_W-1){1'b0}}, 1'b1}));
        // R2
        exact_no_inc_chk: assert (inexact_o || !round_up_o);
        // R5
        tozero_no_inc_chk: assert ((mode_i != 2'b01) || !round_up_o);
        // R10
        tozero_finite_chk: assert ((mode_i != 2'b01) || !ovf_to_inf_o);
        // R10
        nearest_inf_chk: assert ((mode_i != 2'b00) || ovf_to_inf_o);
    end

endmodule

// File: tb/dir_round_unit_tb.sv
`timescale 1ns/1ps
module dir_round_unit_tb;

    localparam int MANT_W = 26;
    localparam int OUT_W  = MANT_W - 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic              sign_i;
    logic [MANT_W-1:0] mant_i;
    logic              sticky_i;
    logic [1:0]        mode_i;
    logic [OUT_W-1:0]  mant_o;
    logic              round_up_o;
    logic              inexact_o;
    logic              ovf_to_inf_o;

    int checks = 0;
    int errors = 0;

    dir_round_unit #(.MANT_W(MANT_W)) u_dut (
        .sign_i       (sign_i),
        .mant_i       (mant_i),
        .sticky_i     (sticky_i),
        .mode_i       (mode_i),
        .mant_o       (mant_o),
        .round_up_o   (round_up_o),
        .inexact_o    (inexact_o),
        .ovf_to_inf_o (ovf_to_inf_o)
    );

    // Drive at the falling edge, let the logic settle, sample before the rise.
    task automatic apply(input logic s, input logic [OUT_W-1:0] kept,
                         input logic g, input logic r, input logic st,
                         input logic [1:0] m);
        @(negedge clk);
        sign_i   = s;
        mant_i   = {kept, g, r};
        sticky_i = st;
        mode_i   = m;
        #1;
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_out(input string req, input logic [OUT_W-1:0] m,
                              input logic ru, input logic nx);
        check(req, "mant_o", 32'(mant_o), 32'(m));
        check(req, "round_up_o", 32'(round_up_o), 32'(ru));
        check(req, "inexact_o", 32'(inexact_o), 32'(nx));
    endtask

    // All-zero inputs: zero mantissa, no flags, nearest picks infinity.
    task automatic t_idle();
        apply(1'b0, '0, 1'b0, 1'b0, 1'b0, 2'b00);
        expect_out("R2", '0, 1'b0, 1'b0);
        check("R10", "ovf_to_inf_o", 32'(ovf_to_inf_o), 32'd1);
    endtask

    // Exact values in every mode and sign: pass-through, no flags (R1, R2).
    task automatic t_exact();
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 2; s++) begin
                apply(s[0], 24'hA5C3_17, 1'b0, 1'b0, 1'b0, m[1:0]);
                expect_out("R2", 24'hA5C3_17, 1'b0, 1'b0);
            end
        end
        apply(1'b0, 24'h12_3456, 1'b0, 1'b0, 1'b0, 2'b00);
        expect_out("R1", 24'h12_3456, 1'b0, 1'b0);
    endtask

    // Nearest mode, ties to even (R4, R3).
    task automatic t_nearest();
        apply(1'b0, 24'h00_0010, 1'b1, 1'b0, 1'b0, 2'b00);   // tie, even
        expect_out("R4", 24'h00_0010, 1'b0, 1'b1);
        apply(1'b0, 24'h00_0011, 1'b1, 1'b0, 1'b0, 2'b00);   // tie, odd
        expect_out("R4", 24'h00_0012, 1'b1, 1'b1);
        apply(1'b1, 24'h00_0010, 1'b1, 1'b1, 1'b0, 2'b00);   // above half
        expect_out("R4", 24'h00_0011, 1'b1, 1'b1);
        apply(1'b0, 24'h00_0010, 1'b1, 1'b0, 1'b1, 2'b00);   // sticky breaks tie
        expect_out("R4", 24'h00_0011, 1'b1, 1'b1);
        apply(1'b0, 24'h00_0011, 1'b0, 1'b1, 1'b1, 2'b00);   // below half
        expect_out("R4", 24'h00_0011, 1'b0, 1'b1);
        apply(1'b0, 24'h00_0010, 1'b0, 1'b0, 1'b1, 2'b00);   // sticky only
        expect_out("R3", 24'h00_0010, 1'b0, 1'b1);
    endtask

    // Toward zero: inexact flagged, never incremented (R5, R3).
    task automatic t_tozero();
        for (int s = 0; s < 2; s++) begin
            apply(s[0], 24'h00_00FF, 1'b1, 1'b1, 1'b1, 2'b01);
            expect_out("R5", 24'h00_00FF, 1'b0, 1'b1);
            apply(s[0], 24'h00_0001, 1'b0, 1'b0, 1'b1, 2'b01);
            expect_out("R3", 24'h00_0001, 1'b0, 1'b1);
        end
    endtask

    // Toward plus infinity (R6).
    task automatic t_posinf();
        apply(1'b0, 24'h00_0020, 1'b0, 1'b0, 1'b1, 2'b10);
        expect_out("R6", 24'h00_0021, 1'b1, 1'b1);
        apply(1'b1, 24'h00_0020, 1'b1, 1'b1, 1'b1, 2'b10);
        expect_out("R6", 24'h00_0020, 1'b0, 1'b1);
        apply(1'b0, 24'h00_0020, 1'b0, 1'b0, 1'b0, 2'b10);
        expect_out("R6", 24'h00_0020, 1'b0, 1'b0);
    endtask

    // Toward minus infinity (R7).
    task automatic t_neginf();
        apply(1'b1, 24'h00_0030, 1'b0, 1'b1, 1'b0, 2'b11);
        expect_out("R7", 24'h00_0031, 1'b1, 1'b1);
        apply(1'b0, 24'h00_0030, 1'b1, 1'b0, 1'b0, 2'b11);
        expect_out("R7", 24'h00_0030, 1'b0, 1'b1);
        apply(1'b1, 24'h00_0030, 1'b0, 1'b0, 1'b0, 2'b11);
        expect_out("R7", 24'h00_0030, 1'b0, 1'b0);
    endtask

    // Carry propagation across chunk borders and the 2.0 form (R8, R9).
    task automatic t_carry();
        apply(1'b0, 24'h7F_FFFF, 1'b1, 1'b1, 1'b0, 2'b00);
        expect_out("R8", 24'h80_0000, 1'b1, 1'b1);
        apply(1'b0, 24'h00_FFFF, 1'b0, 1'b0, 1'b1, 2'b10);
        expect_out("R8", 24'h01_0000, 1'b1, 1'b1);
        apply(1'b1, 24'h3F_00FF, 1'b1, 1'b0, 1'b0, 2'b11);
        expect_out("R9", 24'h3F_0100, 1'b1, 1'b1);
    endtask

    // Overflow saturation choice for every mode and sign (R10).
    task automatic t_ovf();
        logic exp_inf;
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 2; s++) begin
                case (m)
                    0: exp_inf = 1'b1;
                    1: exp_inf = 1'b0;
                    2: exp_inf = (s == 0);
                    default: exp_inf = (s == 1);
                endcase
                apply(s[0], 24'hFF_FFFF, 1'b1, 1'b1, 1'b1, m[1:0]);
                check("R10", "ovf_to_inf_o", 32'(ovf_to_inf_o), 32'(exp_inf));
                apply(s[0], 24'h00_0000, 1'b0, 1'b0, 1'b0, m[1:0]);
                check("R10", "ovf_to_inf_o", 32'(ovf_to_inf_o), 32'(exp_inf));
            end
        end
    endtask

    initial begin
        sign_i   = 1'b0;
        mant_i   = '0;
        sticky_i = 1'b0;
        mode_i   = 2'b00;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_exact();
        t_nearest();
        t_tozero();
        t_posinf();
        t_neginf();
        t_carry();
        t_ovf();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule